// File: doc/BRIEF.md
# Buffered Configuration Port Transfer Engine

This peripheral sits between a host register bus and a 32-bit device configuration port. It holds a local word buffer that the host fills or drains directly. On command, it moves a run of words between that buffer and the port. In the configure direction, words leave the buffer on an output stream that the port can stall. In the readback direction, words arrive on an input stream with a valid flag and are written into the buffer.

The host programs the run length in bytes and the buffer word where the run begins. A single write to the direction register then launches the run. Software polls a done bit until the run is over. Any write to the status register acts as a soft reset: it aborts the run and returns the engine to idle.

Top module: `cfg_xfer_engine`

## Requirements
- R1: The host reaches buffer word n at byte address n*4 for n below 512, and read data appears on `host_rdata` one cycle after the request.
- R2: The size register at byte address 0x800 holds 32 bits and reads back as written. The offset register at 0x804 keeps its low 9 bits and reads zero above them.
- R3: A write to 0x808 starts a run when the engine is idle. Write data bit 0 = 1 selects readback (port to buffer) and 0 selects configure (buffer to port). A read of 0x808 returns 0.
- R4: Bit 0 of the status register at 0x80C reads 1 when no run is active and 0 while a run executes. All other status bits read 0.
- R5: In configure, the engine presents buffer words starting at the offset, one per cycle on `cfg_out_data` with `cfg_out_valid` high. A word is taken on each cycle where `cfg_out_wait` is low, and it is held stable while `cfg_out_wait` is high. The run moves size/4 words, so the low two size bits are dropped.
- R6: In readback, each cycle with `cfg_in_valid` high writes `cfg_in_data` into the next buffer word, starting at the offset. Input that arrives while no run is active is ignored.
- R7: Buffer addresses wrap modulo 512 during a run.
- R8: A run with size/4 equal to 0 completes at once with no port activity.
- R9: A write to 0x808 while a run is active is ignored.
- R10: Any host write to 0x80C aborts an active run. On the next cycle, status reads 1 and `cfg_out_valid` is low.
- R11: After reset, size and offset read 0, status reads 1, and `cfg_out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access request, one cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid the cycle after the request |
| cfg_out_data | output | 32 | Configure word to the port |
| cfg_out_valid | output | 1 | Configure word present |
| cfg_out_wait | input | 1 | Port stall; the word is not taken |
| cfg_in_data | input | 32 | Readback word from the port |
| cfg_in_valid | input | 1 | Readback word present |

## Verification
The hardest situations to reach are those that land in the middle of a run: an abort, or a second direction write, arriving while words are still outstanding. The stimulus reaches them in two ways. It holds the port stall high so that a configure run freezes. It also withholds readback input so that a readback run sits busy. The interfering host write is then issued, and the buffer words that the rest of the run would have touched are read back. Wrapping runs are started at offsets 510 and 511 so that they cross the top of the buffer.

// File: rtl/cfg_xfer_pkg.sv
package cfg_xfer_pkg;
    typedef enum logic [1:0] {
        XM_IDLE = 2'd0,
        XM_CFG  = 2'd1,
        XM_RB   = 2'd2
    } xfer_mode_e;

    // control register word index (byte address bits [3:2])
    localparam logic [1:0] RIDX_SIZE = 2'd0;
    localparam logic [1:0] RIDX_OFFS = 2'd1;
    localparam logic [1:0] RIDX_DIR  = 2'd2;
    localparam logic [1:0] RIDX_STAT = 2'd3;
endpackage

// File: rtl/cfg_xfer_ram.sv
module cfg_xfer_ram #(
    parameter int DEPTH = 512,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
        a_rdata <= mem[a_addr];
    end

    assign b_rdata = mem[b_addr];
endmodule

// File: rtl/cfg_xfer_seq.sv
module cfg_xfer_seq
    import cfg_xfer_pkg::*;
#(
    parameter int AW = 9,
    parameter int CW = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          dir_rb_i,
    input  logic [CW-1:0] words_i,
    input  logic [AW-1:0] offs_i,
    input  logic          abort_i,
    input  logic          out_wait_i,
    input  logic          in_valid_i,
    output logic          out_valid_o,
    output logic          buf_we_o,
    output logic [AW-1:0] buf_addr_o,
    output logic          done_o
);
    typedef struct packed {
        xfer_mode_e    mode;
        logic [AW-1:0] addr;
        logic [CW-1:0] remain;
    } seq_t;

    seq_t s_d, s_q;
    logic step;

    always_comb begin
        s_d  = s_q;
        step = 1'b0;
        case (s_q.mode)
            XM_IDLE: begin
                if (start_i && (words_i != '0)) begin
                    s_d.mode   = dir_rb_i ? XM_RB : XM_CFG;
                    s_d.addr   = offs_i;
                    s_d.remain = words_i;
                end
            end
            XM_CFG:  step = !out_wait_i;
            XM_RB:   step = in_valid_i;
            default: s_d.mode = XM_IDLE;
        endcase
        if (step) begin
            s_d.addr   = s_q.addr + 1'b1;
            s_d.remain = s_q.remain - 1'b1;
            if (s_q.remain == CW'(1)) s_d.mode = XM_IDLE;
        end
        if (abort_i) s_d.mode = XM_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: XM_IDLE, addr: '0, remain: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid_o = (s_q.mode == XM_CFG);
    assign buf_we_o    = (s_q.mode == XM_RB) && in_valid_i;
    assign buf_addr_o  = s_q.addr;
    assign done_o      = (s_q.mode == XM_IDLE);
endmodule

// File: rtl/cfg_xfer_engine.sv
module cfg_xfer_engine
    import cfg_xfer_pkg::*;
#(
    parameter int  BUF_WORDS = 512,
    parameter int  DW        = 32,
    localparam int BW        = $clog2(BUF_WORDS),
    localparam int HA_W      = BW + 3,
    localparam int CW        = DW - 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_req,
    input  logic            host_we,
    input  logic [HA_W-1:0] host_addr,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    output logic [DW-1:0]   cfg_out_data,
    output logic            cfg_out_valid,
    input  logic            cfg_out_wait,
    input  logic [DW-1:0]   cfg_in_data,
    input  logic            cfg_in_valid
);
    typedef struct packed {
        logic [DW-1:0] size;
        logic [BW-1:0] offs;
        logic          rsel;
        logic [DW-1:0] rreg;
    } regs_t;

    regs_t r_d, r_q;

    logic          is_reg, reg_wr, buf_we;
    logic [1:0]    ridx;
    logic [BW-1:0] word_addr;
    logic          dir_wr, abort, zero_start, seq_done, eng_we;
    logic [BW-1:0] eng_addr;
    logic [DW-1:0] ram_rdata;
    logic [CW-1:0] words;
    logic [1:0]    unused_addr_lsb;

    assign unused_addr_lsb = host_addr[1:0];
    assign is_reg     = host_addr[HA_W-1];
    assign ridx       = host_addr[3:2];
    assign word_addr  = host_addr[BW+1:2];
    assign reg_wr     = host_req && host_we && is_reg;
    assign buf_we     = host_req && host_we && !is_reg;
    assign dir_wr     = reg_wr && (ridx == RIDX_DIR);
    assign abort      = reg_wr && (ridx == RIDX_STAT);
    assign words      = r_q.size[DW-1:2];
    assign zero_start = dir_wr && seq_done && (words == '0);

    always_comb begin
        r_d = r_q;
        if (reg_wr && ridx == RIDX_SIZE) r_d.size = host_wdata;
        if (reg_wr && ridx == RIDX_OFFS) r_d.offs = host_wdata[BW-1:0];
        if (host_req && !host_we) begin
            r_d.rsel = is_reg;
            case (ridx)
                RIDX_SIZE: r_d.rreg = r_q.size;
                RIDX_OFFS: r_d.rreg = DW'(r_q.offs);
                RIDX_STAT: r_d.rreg = DW'(seq_done);
                default:   r_d.rreg = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{size: '0, offs: '0, rsel: 1'b0, rreg: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign host_rdata = r_q.rsel ? r_q.rreg : ram_rdata;

    cfg_xfer_ram #(.DEPTH(BUF_WORDS), .DW(DW)) u_ram (
        .clk     (clk),
        .a_we    (buf_we),
        .a_addr  (word_addr),
        .a_wdata (host_wdata),
        .a_rdata (ram_rdata),
        .b_we    (eng_we),
        .b_addr  (eng_addr),
        .b_wdata (cfg_in_data),
        .b_rdata (cfg_out_data)
    );

    cfg_xfer_seq #(.AW(BW), .CW(CW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (dir_wr),
        .dir_rb_i    (host_wdata[0]),
        .words_i     (words),
        .offs_i      (r_q.offs),
        .abort_i     (abort),
        .out_wait_i  (cfg_out_wait),
        .in_valid_i  (cfg_in_valid),
        .out_valid_o (cfg_out_valid),
        .buf_we_o    (eng_we),
        .buf_addr_o  (eng_addr),
        .done_o      (seq_done)
    );
endmodule

// File: rtl/cfg_xfer_engine_chk.sv
module cfg_xfer_engine_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          out_valid,
    input logic          out_wait,
    input logic [DW-1:0] out_data,
    input logic          abort,
    input logic          dir_wr,
    input logic          zero_start,
    input logic          host_buf_we
);
    AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_wait && !abort && !host_buf_we) |=> (out_valid && $stable(out_data))); // R5

    AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        zero_start |=> done); // R8

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (done && !out_valid)); // R10

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_wr && done && !zero_start) |=> !done); // R3

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_wr && !done && !out_valid) |=> !out_valid); // R9

    AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !done); // R4
endmodule

bind cfg_xfer_engine cfg_xfer_engine_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (seq_done),
    .out_valid   (cfg_out_valid),
    .out_wait    (cfg_out_wait),
    .out_data    (cfg_out_data),
    .abort       (abort),
    .dir_wr      (dir_wr),
    .zero_start  (zero_start),
    .host_buf_we (buf_we)
);

// File: tb/cfg_xfer_engine_tb.sv
module cfg_xfer_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [31:0] cfg_out_data;
    logic        cfg_out_valid;
    logic        cfg_out_wait = 1'b0;
    logic [31:0] cfg_in_data = '0;
    logic        cfg_in_valid = 1'b0;

    int total = 0, bad = 0;
    int cyc = 0;
    bit wait_pat = 1'b0, wait_force = 1'b0;
    logic [31:0] cap [0:1023];
    int cap_n = 0;

    always #5 clk = ~clk;

    cfg_xfer_engine u_dut (.*);

    // {dir_rb, offset[8:0], size_bytes[15:0]}
    localparam logic [25:0] VEC [6] = '{
        {1'b0, 9'd0,   16'd16},
        {1'b0, 9'd510, 16'd16},
        {1'b1, 9'd5,   16'd12},
        {1'b1, 9'd511, 16'd8},
        {1'b0, 9'd100, 16'd14},
        {1'b1, 9'd300, 16'd40}
    };

    // port model: choose stall for the next edge, then record the word taken there
    always @(negedge clk) begin
        cyc++;
        cfg_out_wait = wait_force || (wait_pat && (cyc % 3 == 1));
        if (cfg_out_valid && !cfg_out_wait && cap_n < 1024) begin
            cap[cap_n] = cfg_out_data;
            cap_n++;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        d = host_rdata;
        host_req = 1'b0;
    endtask

    task automatic wait_done(string req);
        logic [31:0] s;
        s = 32'h0;
        for (int k = 0; k < 3000; k++) begin
            rd(12'h80C, s);
            if (s[0]) break;
        end
        chk(req, s, 32'h1);
    endtask

    task automatic feed(int n, logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_in_valid = 1'b1; cfg_in_data = base + i;
            @(negedge clk);
            cfg_in_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk("R11 out_valid", {31'b0, cfg_out_valid}, 32'h0);
        rd(12'h800, d); chk("R11 size", d, 32'h0);
        rd(12'h804, d); chk("R11 offset", d, 32'h0);
        rd(12'h80C, d); chk("R11 status", d, 32'h1);

        // R1 buffer access, R2 register readback, R3 direction reads 0
        wr(12'h000, 32'h1111_2222);
        wr(12'h7FC, 32'h3333_4444);
        rd(12'h000, d); chk("R1 word0", d, 32'h1111_2222);
        rd(12'h7FC, d); chk("R1 word511", d, 32'h3333_4444);
        wr(12'h800, 32'hCAFE_F00D);
        rd(12'h800, d); chk("R2 size", d, 32'hCAFE_F00D);
        wr(12'h804, 32'hFFFF_FFFF);
        rd(12'h804, d); chk("R2 offset mask", d, 32'h0000_01FF);
        rd(12'h808, d); chk("R3 dir reads 0", d, 32'h0);

        // vector table: R3 R5 R6 R7
        for (int v = 0; v < 6; v++) begin
            logic        dir;
            int          off, n;
            dir = VEC[v][25];
            off = int'(VEC[v][24:16]);
            n   = int'(VEC[v][15:0]) / 4;
            wr(12'h800, 32'(VEC[v][15:0]));
            wr(12'h804, 32'(off));
            if (!dir) begin
                for (int i = 0; i < n; i++)
                    wr(12'(((off + i) % 512) * 4), 32'h5A00_0000 + (v << 16) + ((off + i) % 512));
                cap_n = 0;
                wait_pat = 1'b1;
                wr(12'h808, 32'h0);
                wait_done("R4 cfg done");
                wait_pat = 1'b0;
                chk("R5 cfg word count", 32'(cap_n), 32'(n));
                for (int i = 0; i < n; i++)
                    chk("R5 R7 cfg word", cap[i], 32'h5A00_0000 + (v << 16) + ((off + i) % 512));
            end else begin
                wr(12'(((off + n) % 512) * 4), 32'hDEAD_0000 + v);
                wr(12'h808, 32'h1);
                rd(12'h80C, d); chk("R4 busy", d, 32'h0);
                feed(n, 32'h7700_0000 + (v << 8));
                wait_done("R4 rb done");
                feed(2, 32'hBAD0_0000);
                for (int i = 0; i < n; i++) begin
                    rd(12'(((off + i) % 512) * 4), d);
                    chk("R6 R7 rb word", d, 32'h7700_0000 + (v << 8) + i);
                end
                rd(12'(((off + n) % 512) * 4), d);
                chk("R6 idle input ignored", d, 32'hDEAD_0000 + v);
            end
        end

        // R8 size below one word
        wr(12'h800, 32'h3);
        cap_n = 0;
        wr(12'h808, 32'h0);
        rd(12'h80C, d); chk("R8 zero run done", d, 32'h1);
        chk("R8 no port words", 32'(cap_n), 32'h0);

        // R9 direction write while readback busy
        wr(12'h800, 32'h8);
        wr(12'h804, 32'd20);
        wr(12'h808, 32'h1);
        wr(12'h808, 32'h0);
        @(negedge clk);
        chk("R9 no configure start", {31'b0, cfg_out_valid}, 32'h0);
        rd(12'h80C, d); chk("R9 still busy", d, 32'h0);
        feed(2, 32'h4400_0000);
        wait_done("R9 done");
        rd(12'h050, d); chk("R9 word20", d, 32'h4400_0000);
        rd(12'h054, d); chk("R9 word21", d, 32'h4400_0001);

        // R10 abort readback part way
        wr(12'h0A8, 32'h0); wr(12'h0AC, 32'h0);
        wr(12'h800, 32'd16);
        wr(12'h804, 32'd40);
        wr(12'h808, 32'h1);
        feed(2, 32'h6600_0000);
        wr(12'h80C, 32'h0000_FEFE);
        rd(12'h80C, d); chk("R10 rb abort idle", d, 32'h1);
        feed(2, 32'h6600_0002);
        rd(12'h0A0, d); chk("R10 word40", d, 32'h6600_0000);
        rd(12'h0A8, d); chk("R10 word42 untouched", d, 32'h0);
        rd(12'h0AC, d); chk("R10 word43 untouched", d, 32'h0);

        // R10 abort stalled configure
        wait_force = 1'b1;
        wr(12'h800, 32'd40);
        wr(12'h804, 32'd0);
        wr(12'h808, 32'h0);
        @(negedge clk);
        chk("R5 stalled valid", {31'b0, cfg_out_valid}, 32'h1);
        wr(12'h80C, 32'h0);
        chk("R10 cfg abort valid low", {31'b0, cfg_out_valid}, 32'h0);
        rd(12'h80C, d); chk("R10 cfg abort idle", d, 32'h1);
        wait_force = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule